// File: doc/BRIEF.md
# BCD Calendar Clock Register Block

This block keeps wall-clock time and calendar date as a set of byte-wide binary-coded-decimal registers: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A single-cycle pulse on the 1 Hz tick input advances the seconds. Carries ripple through minutes, hours, day, month and year. Month lengths are respected, including 29-day Februaries in leap years.

Software reaches the clock through a small byte bus with a shared address, write data, write strobe and read strobe. Each field write is range-checked. A value outside the field's legal range, or one with a decimal digit above 9, is dropped without any effect. The seconds byte carries a halt flag in its top bit that freezes timekeeping. The weekday byte carries a general-purpose flag. A separate control byte has some of its bits held at fixed values.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the registers read: control 0x90, seconds 0x00 with the halt flag clear, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00. The register select is address 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year.
- R2: A seconds or minutes write uses data bits 6:0 as BCD. It takes effect only when both digits are 0-9 and the value is 00-59; otherwise the field keeps its value.
- R3: An hours write uses data bits 5:0 as BCD and takes effect only for 00-23. Bits 7:6 are discarded.
- R4: A day write uses bits 5:0 and takes effect only for 01-31. A month write uses bits 4:0 and takes effect only for 01-12. A year write uses all 8 bits and takes effect only for 00-99. A rejected write leaves the field unchanged.
- R5: Bit 7 of every seconds write sets the halt flag, even when the seconds value itself is rejected. While the flag is 1, ticks do not advance time. Clearing it resumes counting from the held value. A seconds read returns the flag in bit 7 and the BCD seconds in bits 6:0.
- R6: A tick with the halt flag clear advances seconds by one. The carry runs 59 to 00 into minutes, 59 to 00 into hours, and 23 to 00 into day and weekday. It continues from the month's last day to day 01 into month, and from 12 to 01 into year. Year 99 wraps to 00.
- R7: Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and 04, 06, 09 and 11 have 30. February has 29 days when the year value is a multiple of 4, else 28. A day at or past the month's length rolls to 01 on the next day carry.
- R8: A weekday write stores bits 2:0 as the weekday and bit 6 as a flag, and a read returns both in those positions with the other bits 0. The day carry advances the weekday from 7 (or 0) to 1, otherwise by one, and leaves the flag alone.
- R9: A control write stores the data with bit 5 cleared and bits 7 and 4 set.
- R10: A tick in the same cycle as a write strobe to any clock field (addresses 1-7) is discarded. The write applies and time does not advance.
- R11: A read strobe loads the read data output at the next clock edge with the selected register's value. Without a strobe the output holds. Addresses above 7 read as 0xFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| addr | input | ADDR_W | Register select for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
Several properties are checked on every cycle. Every counter field stays a legal BCD value inside its range. The control byte always carries its fixed bits. A halted clock never changes seconds. An unhalted tick with no competing write always moves seconds. A tick that collides with a field write leaves seconds alone. An invalid year write leaves the year untouched. Calendar facts need the bench's directed scenarios: month-length and leap-year rollover, the year wrap, the weekday wrap with its flag kept, and read-back formats.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 3;
    localparam logic [BYTE_W-1:0] CTRL_SET_MASK = 8'h90;
    localparam logic [BYTE_W-1:0] CTRL_CLR_MASK = 8'h20;
    localparam logic [BYTE_W-1:0] UNMAPPED_READ = 8'hFF;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 3'd0,
        SEL_SEC   = 3'd1,
        SEL_MIN   = 3'd2,
        SEL_HOUR  = 3'd3,
        SEL_WDAY  = 3'd4,
        SEL_DATE  = 3'd5,
        SEL_MONTH = 3'd6,
        SEL_YEAR  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic       halt;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       wflag;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        logic ctrl;
        logic halt;
        logic sec;
        logic min;
        logic hour;
        logic wday;
        logic date;
        logic month;
        logic year;
        logic field_hit;
    } wr_accept_t;

    // True when both digits are decimal and lo <= b <= hi (lo/hi in BCD).
    function automatic logic bcd_in_range(input logic [7:0] b,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9) && (b >= lo) && (b <= hi);
    endfunction

    // Next BCD value, no wrap handling (caller decides the wrap).
    function automatic logic [7:0] bcd_next(input logic [7:0] b);
        logic [7:0] r;
        if (b[3:0] >= 4'd9) begin
            r = {b[7:4] + 4'd1, 4'd0};
        end else begin
            r = {b[7:4], b[3:0] + 4'd1};
        end
        return r;
    endfunction

    // Leap test on a BCD year: multiple of 4 when even tens digit and ones in
    // {0,4,8}, or odd tens digit and ones in {2,6}.
    function automatic logic bcd_leap(input logic [7:0] y);
        logic even_t;
        even_t = ~y[4];
        if (even_t) begin
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        end
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Length of a month as a BCD byte.
    function automatic logic [7:0] bcd_month_len(input logic [4:0] m,
                                                 input logic [7:0] y);
        logic [7:0] len;
        case (m)
            5'h02:                      len = bcd_leap(y) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: len = 8'h30;
            default:                    len = 8'h31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_write_filter.sv
module rtc_write_filter
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output wr_accept_t        acc
);

    logic     in_map;
    reg_sel_e sel;

    generate
        if (ADDR_W > SEL_W) begin : g_wide
            assign in_map = ~|addr[ADDR_W-1:SEL_W];
        end else begin : g_exact
            assign in_map = 1'b1;
        end
    endgenerate

    assign sel = reg_sel_e'(addr[SEL_W-1:0]);

    logic wr_ok;
    logic [7:0] sec_v, min_v, hour_v, date_v, month_v;

    always_comb begin
        wr_ok   = wr_en && in_map;
        sec_v   = {1'b0, wr_data[6:0]};
        min_v   = {1'b0, wr_data[6:0]};
        hour_v  = {2'b00, wr_data[5:0]};
        date_v  = {2'b00, wr_data[5:0]};
        month_v = {3'b000, wr_data[4:0]};

        acc           = '0;
        acc.field_hit = wr_ok && (sel != SEL_CTRL);
        acc.ctrl      = wr_ok && (sel == SEL_CTRL);
        acc.halt      = wr_ok && (sel == SEL_SEC);
        acc.sec       = wr_ok && (sel == SEL_SEC)   && bcd_in_range(sec_v,   8'h00, 8'h59);
        acc.min       = wr_ok && (sel == SEL_MIN)   && bcd_in_range(min_v,   8'h00, 8'h59);
        acc.hour      = wr_ok && (sel == SEL_HOUR)  && bcd_in_range(hour_v,  8'h00, 8'h23);
        acc.wday      = wr_ok && (sel == SEL_WDAY);
        acc.date      = wr_ok && (sel == SEL_DATE)  && bcd_in_range(date_v,  8'h01, 8'h31);
        acc.month     = wr_ok && (sel == SEL_MONTH) && bcd_in_range(month_v, 8'h01, 8'h12);
        acc.year      = wr_ok && (sel == SEL_YEAR)  && bcd_in_range(wr_data, 8'h00, 8'h99);
    end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
#(
    parameter logic [2:0] WDAY_RESET = 3'd1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic [7:0] wr_data,
    input  wr_accept_t acc,
    output rtc_time_t  cur
);

    rtc_time_t  nxt;
    logic       advance;
    logic [7:0] sec_b, min_b, hour_b, date_b, month_b;
    logic [7:0] month_len;

    always_comb begin
        sec_b     = {1'b0, cur.sec};
        min_b     = {1'b0, cur.min};
        hour_b    = {2'b00, cur.hour};
        date_b    = {2'b00, cur.date};
        month_b   = {3'b000, cur.month};
        month_len = bcd_month_len(cur.month, cur.year);
        advance   = tick_1hz && !cur.halt && !acc.field_hit;

        nxt = cur;
        if (advance) begin
            if (sec_b != 8'h59) begin
                nxt.sec = bcd_next(sec_b)[6:0];
            end else begin
                nxt.sec = '0;
                if (min_b != 8'h59) begin
                    nxt.min = bcd_next(min_b)[6:0];
                end else begin
                    nxt.min = '0;
                    if (hour_b != 8'h23) begin
                        nxt.hour = bcd_next(hour_b)[5:0];
                    end else begin
                        nxt.hour = '0;
                        nxt.wday = (cur.wday == 3'd7 || cur.wday == 3'd0)
                                   ? 3'd1 : cur.wday + 3'd1;
                        if (date_b < month_len) begin
                            nxt.date = bcd_next(date_b)[5:0];
                        end else begin
                            nxt.date = 6'h01;
                            if (month_b != 8'h12) begin
                                nxt.month = bcd_next(month_b)[4:0];
                            end else begin
                                nxt.month = 5'h01;
                                nxt.year  = (cur.year == 8'h99) ? 8'h00
                                                                : bcd_next(cur.year);
                            end
                        end
                    end
                end
            end
        end

        if (acc.halt)  nxt.halt  = wr_data[7];
        if (acc.sec)   nxt.sec   = wr_data[6:0];
        if (acc.min)   nxt.min   = wr_data[6:0];
        if (acc.hour)  nxt.hour  = wr_data[5:0];
        if (acc.wday) begin
            nxt.wday  = wr_data[2:0];
            nxt.wflag = wr_data[6];
        end
        if (acc.date)  nxt.date  = wr_data[5:0];
        if (acc.month) nxt.month = wr_data[4:0];
        if (acc.year)  nxt.year  = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            cur.wday  <= WDAY_RESET;
            cur.date  <= 6'h01;
            cur.month <= 5'h01;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  rtc_time_t         cur,
    input  logic [7:0]        ctrl,
    output logic [7:0]        rd_data
);

    logic       in_map;
    logic [7:0] sel_val;

    generate
        if (ADDR_W > SEL_W) begin : g_wide
            assign in_map = ~|addr[ADDR_W-1:SEL_W];
        end else begin : g_exact
            assign in_map = 1'b1;
        end
    endgenerate

    always_comb begin
        case (reg_sel_e'(addr[SEL_W-1:0]))
            SEL_CTRL:  sel_val = ctrl;
            SEL_SEC:   sel_val = {cur.halt, cur.sec};
            SEL_MIN:   sel_val = {1'b0, cur.min};
            SEL_HOUR:  sel_val = {2'b00, cur.hour};
            SEL_WDAY:  sel_val = {1'b0, cur.wflag, 3'b000, cur.wday};
            SEL_DATE:  sel_val = {2'b00, cur.date};
            SEL_MONTH: sel_val = {3'b000, cur.month};
            default:   sel_val = cur.year;
        endcase
        if (!in_map) sel_val = UNMAPPED_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel_val;
        end
    end

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
    import rtc_pkg::*;
#(
    parameter int         ADDR_W     = 3,
    parameter logic [2:0] WDAY_RESET = 3'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data
);

    wr_accept_t acc;
    rtc_time_t  cur_time;
    logic [7:0] ctrl_q;

    rtc_write_filter #(.ADDR_W(ADDR_W)) u_filter (
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .acc     (acc)
    );

    rtc_time_chain #(.WDAY_RESET(WDAY_RESET)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .tick_1hz (tick_1hz),
        .wr_data  (wr_data),
        .acc      (acc),
        .cur      (cur_time)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_SET_MASK;
        end else if (acc.ctrl) begin
            ctrl_q <= (wr_data & ~CTRL_CLR_MASK) | CTRL_SET_MASK;
        end
    end

    rtc_read_port #(.ADDR_W(ADDR_W)) u_read (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (addr),
        .cur     (cur_time),
        .ctrl    (ctrl_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wr_data,
    input rtc_time_t         t,
    input logic [7:0]        ctrl
);

    logic       mapped;
    logic       fld_wr;
    logic       sec_wr;
    logic       year_wr_bad;

    assign mapped      = (addr >> 3) == '0;
    assign fld_wr      = wr_en && mapped && (addr[2:0] != 3'd0);
    assign sec_wr      = wr_en && mapped && (addr[2:0] == 3'd1);
    assign year_wr_bad = wr_en && mapped && (addr[2:0] == 3'd7) &&
                         (wr_data[7:4] > 4'd9 || wr_data[3:0] > 4'd9);

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        t.sec[3:0] <= 4'd9 && t.sec[6:4] <= 3'd5);                       // R2
    AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (rst)
        t.hour[3:0] <= 4'd9 && t.hour <= 6'h23);                          // R3
    AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (rst)
        t.month >= 5'h01 && t.month <= 5'h12 && t.month[3:0] <= 4'd9);    // R4
    AST_DATE_RANGE: assert property (@(posedge clk) disable iff (rst)
        t.date >= 6'h01 && t.date <= 6'h31 && t.date[3:0] <= 4'd9);       // R7
    AST_YEAR_REJECT: assert property (@(posedge clk) disable iff (rst)
        year_wr_bad |=> $stable(t.year));                                 // R4
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (t.halt && !sec_wr) |=> $stable(t.sec));                          // R5
    AST_TICK_MOVES: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !t.halt && !fld_wr) |=> (t.sec != $past(t.sec)));    // R6
    AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (rst)
        ctrl[7] && ctrl[4] && !ctrl[5]);                                  // R9
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && fld_wr && !sec_wr) |=> $stable(t.sec));              // R10

endmodule

bind bcd_rtc_regs bcd_rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_1hz (tick_1hz),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .t        (cur_time),
    .ctrl     (ctrl_q)
);

// File: tb/bcd_rtc_regs_bench.sv
module bcd_rtc_regs_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    bcd_rtc_regs u_bcd_rtc_regs (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp,
                          input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d got=%02h exp=%02h", req, a, rd_data, exp);
        end
    endtask

    task automatic set_clock(input logic [7:0] y, input logic [7:0] m,
                             input logic [7:0] d, input logic [7:0] h,
                             input logic [7:0] mi, input logic [7:0] s);
        wr(3'd7, y); wr(3'd6, m); wr(3'd5, d);
        wr(3'd3, h); wr(3'd2, mi); wr(3'd1, s);
    endtask

    task automatic t_reset();
        rd_chk(3'd0, 8'h90, "R1");
        rd_chk(3'd1, 8'h00, "R1");
        rd_chk(3'd2, 8'h00, "R1");
        rd_chk(3'd3, 8'h00, "R1");
        rd_chk(3'd4, 8'h01, "R1");
        rd_chk(3'd5, 8'h01, "R1");
        rd_chk(3'd6, 8'h01, "R1");
        rd_chk(3'd7, 8'h00, "R1");
    endtask

    task automatic t_field_limits();
        wr(3'd2, 8'h45); rd_chk(3'd2, 8'h45, "R2 minutes ok");
        wr(3'd2, 8'h60); rd_chk(3'd2, 8'h45, "R2 minutes 60 dropped");
        wr(3'd2, 8'h3A); rd_chk(3'd2, 8'h45, "R2 minutes bad nibble");
        wr(3'd1, 8'h37); rd_chk(3'd1, 8'h37, "R2 seconds ok");
        wr(3'd3, 8'h23); rd_chk(3'd3, 8'h23, "R3 hours ok");
        wr(3'd3, 8'h24); rd_chk(3'd3, 8'h23, "R3 hours 24 dropped");
        wr(3'd3, 8'hC5); rd_chk(3'd3, 8'h05, "R3 upper bits masked");
        wr(3'd5, 8'h00); rd_chk(3'd5, 8'h01, "R4 day zero dropped");
        wr(3'd5, 8'h31); rd_chk(3'd5, 8'h31, "R4 day 31 ok");
        wr(3'd5, 8'h32); rd_chk(3'd5, 8'h31, "R4 day 32 dropped");
        wr(3'd6, 8'h13); rd_chk(3'd6, 8'h01, "R4 month 13 dropped");
        wr(3'd6, 8'h00); rd_chk(3'd6, 8'h01, "R4 month 0 dropped");
        wr(3'd6, 8'h12); rd_chk(3'd6, 8'h12, "R4 month ok");
        wr(3'd7, 8'h9A); rd_chk(3'd7, 8'h00, "R4 year bad nibble");
        wr(3'd7, 8'h99); rd_chk(3'd7, 8'h99, "R4 year ok");
    endtask

    task automatic t_halt();
        wr(3'd1, 8'h90);
        tick(); tick(); tick();
        rd_chk(3'd1, 8'h90, "R5 halted");
        wr(3'd1, 8'h10);
        tick();
        rd_chk(3'd1, 8'h11, "R5 resumed");
        wr(3'd1, 8'hE0);
        rd_chk(3'd1, 8'h91, "R5 flag set by rejected seconds");
        wr(3'd1, 8'h11);
    endtask

    task automatic t_carry();
        wr(3'd4, 8'h03);
        set_clock(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        tick();
        rd_chk(3'd1, 8'h00, "R6 sec wrap");
        rd_chk(3'd2, 8'h00, "R6 min wrap");
        rd_chk(3'd3, 8'h00, "R6 hour wrap");
        rd_chk(3'd5, 8'h01, "R7 feb 28 non-leap");
        rd_chk(3'd6, 8'h03, "R7 month carry");
        rd_chk(3'd4, 8'h04, "R8 weekday carry");
        set_clock(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        tick();
        rd_chk(3'd5, 8'h29, "R7 leap feb 29");
        wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
        tick();
        rd_chk(3'd5, 8'h01, "R7 leap feb end");
        rd_chk(3'd6, 8'h03, "R7 leap march");
        set_clock(8'h50, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        tick();
        rd_chk(3'd6, 8'h05, "R7 30-day month");
        wr(3'd1, 8'h09); tick();
        rd_chk(3'd1, 8'h10, "R6 seconds digit carry");
    endtask

    task automatic t_year_wrap();
        wr(3'd4, 8'h47);
        rd_chk(3'd4, 8'h47, "R8 weekday with flag");
        set_clock(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        tick();
        rd_chk(3'd7, 8'h00, "R6 year wrap");
        rd_chk(3'd6, 8'h01, "R6 month wrap");
        rd_chk(3'd5, 8'h01, "R6 day wrap");
        rd_chk(3'd4, 8'h41, "R8 weekday 7 to 1 flag kept");
    endtask

    task automatic t_ctrl();
        wr(3'd0, 8'h2F); rd_chk(3'd0, 8'h9F, "R9 ctrl 2F");
        wr(3'd0, 8'hFF); rd_chk(3'd0, 8'hDF, "R9 ctrl FF");
        wr(3'd0, 8'h00); rd_chk(3'd0, 8'h90, "R9 ctrl 00");
    endtask

    task automatic t_priority();
        wr(3'd1, 8'h05);
        @(negedge clk);
        addr = 3'd2; wr_data = 8'h07; wr_en = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        rd_chk(3'd1, 8'h05, "R10 tick dropped");
        rd_chk(3'd2, 8'h07, "R10 write applied");
        @(negedge clk);
        addr = 3'd0; wr_data = 8'h01; wr_en = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        rd_chk(3'd1, 8'h06, "R10 ctrl write keeps tick");
    endtask

    task automatic t_read_hold();
        rd_chk(3'd2, 8'h07, "R11 read");
        @(negedge clk);
        addr = 3'd0;
        @(negedge clk);
        total++;
        if (rd_data !== 8'h07) begin
            bad++;
            $display("FAIL R11 hold got=%02h exp=%02h", rd_data, 8'h07);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_field_limits();
        t_halt();
        t_carry();
        t_year_wrap();
        t_ctrl();
        t_priority();
        t_read_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule